// File: doc/BRIEF.md
# Interrupt steering multiplexer

This block collects a wide bank of level-sensitive interrupt sources and reduces them to a handful of output lines. Each output line is assigned to a fixed band of 64 inputs. An output line is raised while any input in its band is pending and enabled. An input is pending when its raw wire is high or when software has forced it through a software-set bit. A one-hot channel register chooses the destination that the output lines are steered to, and the block drives that choice out as a select vector.

Software reaches the block through a simple word-addressed register port. The port holds a channel register, a bank of enable words, a bank of software-set words and a bank of read-only status words. Each word covers 32 inputs. Inside every bank the words run in reverse input order, so word 0 holds the highest-numbered inputs. The input count is a parameter and must be a multiple of 32. The number of output lines is the input count divided by 64, rounded up, and must lie between 1 and 8.

Top module: `irq_steer_mux`

## Requirements
- R1: After synchronous reset, every output line is low, the channel select is zero, and all enable and software-set bits read back as zero.
- R2: With W = NUM_IN/32 words, enable word w sits at byte address 4+4w and reads back what was last written to it. Bit b of any word w stands for input (W-1-w)*32+b, so word 0 holds the top 32 inputs.
- R3: Status word w, at byte address 8W+4+4w, reads as the raw inputs of that word ORed with its software-set bits.
- R4: Software-set word w sits at byte address 4W+4+4w. Writing it sets every bit written as 1, leaves bits written as 0 unchanged, and reads back the stored set bits.
- R5: Writing status word w clears every software-set bit written as 1 and leaves the others unchanged. The raw input still shows in the status read.
- R6: Output line k goes high one clock after any input in the range 64k..64k+63 is both pending and enabled, and it falls one clock after no such input remains.
- R7: An input whose enable bit is 0 never raises an output line, whether it is pending by wire or by software-set.
- R8: A write to byte address 0 with at most one bit set, and no bit at or above CHAN_W, updates the channel select output. Any other value written there is ignored.
- R9: Read data appears on the port one clock after a read strobe and holds until the next read. Reads of unaligned or unmapped addresses return zero.
- R10: When NUM_IN is not a multiple of 64, the last output line serves only the remaining 32 inputs and is unaffected by any other input.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_in | input | NUM_IN | Raw level interrupt inputs, bit n is input n |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | ADDR_W | Byte address of the register word |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid one clock after bus_rd |
| chan_sel | output | CHAN_W | One-hot channel select, zero for none |
| irq_out | output | (NUM_IN+63)/64 | Aggregated output lines, one per band of 64 inputs |

## Verification
The hardest situation to reach from the ports is a band where wire-pending and software-set sources of the same input overlap with an enable change in the same short window. The output must follow all three without a spurious pulse. Only the reversed word order links a register word to the inputs of a given band. The stimulus therefore pairs directed writes, aimed at the first and last word and at the short final band, with a long run of seeded random input patterns interleaved with random enable, set and clear writes. After every step it compares every output line and a sampled status word against a reference model kept in the bench.

// File: rtl/irqs_pkg.sv
package irqs_pkg;

    localparam int WORD_BITS  = 32;
    localparam int GROUP_BITS = 64;
    localparam int MAX_OUTS   = 8;

    typedef enum logic [2:0] {
        RK_NONE,
        RK_CTRL,
        RK_MASK,
        RK_SET,
        RK_STAT
    } reg_kind_e;

    typedef struct packed {
        reg_kind_e  kind;
        logic [7:0] idx;
    } reg_sel_t;

    // Map a byte address onto a bank and a word index inside the bank.
    function automatic reg_sel_t decode_addr(input logic [31:0] addr, input int words);
        reg_sel_t s;
        int       wa;
        s.kind = RK_NONE;
        s.idx  = '0;
        wa     = int'(addr[31:2]);
        if (addr[1:0] == 2'b00) begin
            if (wa == 0) begin
                s.kind = RK_CTRL;
            end else if (wa <= words) begin
                s.kind = RK_MASK;
                s.idx  = 8'(wa - 1);
            end else if (wa <= 2 * words) begin
                s.kind = RK_SET;
                s.idx  = 8'(wa - 1 - words);
            end else if (wa <= 3 * words) begin
                s.kind = RK_STAT;
                s.idx  = 8'(wa - 1 - 2 * words);
            end
        end
        return s;
    endfunction

    // Input band (group of 32) held by register word w: words are reversed.
    function automatic int word_to_band(input int w, input int words);
        return words - 1 - w;
    endfunction

endpackage

// File: rtl/irqs_regbank.sv
module irqs_regbank
    import irqs_pkg::*;
#(
    parameter int NUM_IN = 160,
    parameter int CHAN_W = 8,
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [NUM_IN-1:0] irq_in,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic [NUM_IN-1:0] mask_q,
    output logic [NUM_IN-1:0] set_q,
    output logic [CHAN_W-1:0] chan_sel
);

    localparam int WORDS = NUM_IN / WORD_BITS;

    reg_sel_t          sel;
    logic [CHAN_W-1:0] ctrl_q;
    logic [31:0]       rd_word;
    logic [31:0]       rdata_q;
    logic              ctrl_ok;
    int                rd_band;

    assign sel = decode_addr(32'(bus_addr), WORDS);

    // Mask and software-set storage, one 32-bit slice per register word.
    for (genvar w = 0; w < WORDS; w++) begin : g_word
        localparam int BAND = WORDS - 1 - w;
        logic hit_mask, hit_set, hit_stat;
        assign hit_mask = bus_wr && (sel.kind == RK_MASK) && (sel.idx == 8'(w));
        assign hit_set  = bus_wr && (sel.kind == RK_SET)  && (sel.idx == 8'(w));
        assign hit_stat = bus_wr && (sel.kind == RK_STAT) && (sel.idx == 8'(w));

        always_ff @(posedge clk) begin
            if (rst) begin
                mask_q[BAND*WORD_BITS +: WORD_BITS] <= '0;
                set_q[BAND*WORD_BITS +: WORD_BITS]  <= '0;
            end else begin
                if (hit_mask)
                    mask_q[BAND*WORD_BITS +: WORD_BITS] <= bus_wdata;
                if (hit_set)
                    set_q[BAND*WORD_BITS +: WORD_BITS] <=
                        set_q[BAND*WORD_BITS +: WORD_BITS] | bus_wdata;
                else if (hit_stat)
                    set_q[BAND*WORD_BITS +: WORD_BITS] <=
                        set_q[BAND*WORD_BITS +: WORD_BITS] & ~bus_wdata;
            end
        end
    end

    // Channel register accepts only one-hot or zero values within its width.
    assign ctrl_ok = $onehot0(bus_wdata) && ((bus_wdata >> CHAN_W) == 32'd0);

    always_ff @(posedge clk) begin
        if (rst)
            ctrl_q <= '0;
        else if (bus_wr && sel.kind == RK_CTRL && ctrl_ok)
            ctrl_q <= bus_wdata[CHAN_W-1:0];
    end

    assign chan_sel = ctrl_q;

    // Read mux over the three word banks.
    always_comb begin
        rd_band = word_to_band(int'(sel.idx), WORDS);
        rd_word = '0;
        case (sel.kind)
            RK_CTRL: rd_word = 32'(ctrl_q);
            RK_MASK: rd_word = mask_q[rd_band*WORD_BITS +: WORD_BITS];
            RK_SET:  rd_word = set_q[rd_band*WORD_BITS +: WORD_BITS];
            RK_STAT: rd_word = irq_in[rd_band*WORD_BITS +: WORD_BITS]
                             | set_q[rd_band*WORD_BITS +: WORD_BITS];
            default: rd_word = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst)
            rdata_q <= '0;
        else if (bus_rd)
            rdata_q <= rd_word;
    end

    assign bus_rdata = rdata_q;

    // Enables only move on a write to the enable bank.
    assert_mask_hold_R2: assert property (@(posedge clk) disable iff (rst)
        !(bus_wr && sel.kind == RK_MASK) |=> $stable(mask_q));

    // Software-set bits only move on a set or status write.
    assert_set_hold_R4: assert property (@(posedge clk) disable iff (rst)
        !(bus_wr && (sel.kind == RK_SET || sel.kind == RK_STAT)) |=> $stable(set_q));

    // A rejected channel value leaves the select unchanged.
    assert_ctrl_reject_R8: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && sel.kind == RK_CTRL && !ctrl_ok) |=> $stable(chan_sel));

    assert_ctrl_onehot_R8: assert property (@(posedge clk) disable iff (rst)
        $onehot0(chan_sel));

    // Read data holds between read strobes.
    assert_rdata_hold_R9: assert property (@(posedge clk) disable iff (rst)
        !bus_rd |=> $stable(bus_rdata));

endmodule

// File: rtl/irqs_aggregate.sv
module irqs_aggregate
    import irqs_pkg::*;
#(
    parameter int NUM_IN  = 160,
    parameter int NUM_OUT = (NUM_IN + GROUP_BITS - 1) / GROUP_BITS
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [NUM_IN-1:0]  irq_in,
    input  logic [NUM_IN-1:0]  mask_q,
    input  logic [NUM_IN-1:0]  set_q,
    output logic [NUM_OUT-1:0] irq_out
);

    for (genvar k = 0; k < NUM_OUT; k++) begin : g_out
        localparam int LO = k * GROUP_BITS;
        localparam int HI = (LO + GROUP_BITS - 1 < NUM_IN) ? LO + GROUP_BITS - 1 : NUM_IN - 1;
        logic band_hit;
        logic out_q;

        assign band_hit = |((irq_in[HI:LO] | set_q[HI:LO]) & mask_q[HI:LO]);

        always_ff @(posedge clk) begin
            if (rst)
                out_q <= 1'b0;
            else
                out_q <= band_hit;
        end

        assign irq_out[k] = out_q;

        // A fully disabled band cannot raise its line.
        assert_masked_quiet_R7: assert property (@(posedge clk) disable iff (rst)
            (mask_q[HI:LO] == '0) |=> !irq_out[k]);
    end

endmodule

// File: rtl/irq_steer_mux.sv
module irq_steer_mux
    import irqs_pkg::*;
#(
    parameter int NUM_IN = 160,
    parameter int CHAN_W = 8,
    parameter int ADDR_W = 8,
    localparam int NUM_OUT = (NUM_IN + GROUP_BITS - 1) / GROUP_BITS
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [NUM_IN-1:0]  irq_in,
    input  logic               bus_wr,
    input  logic               bus_rd,
    input  logic [ADDR_W-1:0]  bus_addr,
    input  logic [31:0]        bus_wdata,
    output logic [31:0]        bus_rdata,
    output logic [CHAN_W-1:0]  chan_sel,
    output logic [NUM_OUT-1:0] irq_out
);

    logic [NUM_IN-1:0] mask_q;
    logic [NUM_IN-1:0] set_q;

    irqs_regbank #(
        .NUM_IN (NUM_IN),
        .CHAN_W (CHAN_W),
        .ADDR_W (ADDR_W)
    ) i_regbank (
        .clk       (clk),
        .rst       (rst),
        .irq_in    (irq_in),
        .bus_wr    (bus_wr),
        .bus_rd    (bus_rd),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .mask_q    (mask_q),
        .set_q     (set_q),
        .chan_sel  (chan_sel)
    );

    irqs_aggregate #(
        .NUM_IN  (NUM_IN),
        .NUM_OUT (NUM_OUT)
    ) i_aggregate (
        .clk     (clk),
        .rst     (rst),
        .irq_in  (irq_in),
        .mask_q  (mask_q),
        .set_q   (set_q),
        .irq_out (irq_out)
    );

    // Leaving reset, the lines and the select are quiet.
    assert_reset_quiet_R1: assert property (@(posedge clk)
        $fell(rst) |-> (irq_out == '0 && chan_sel == '0));

endmodule

// File: tb/test_irq_steer_mux.sv
`timescale 1ns/1ps
module test_irq_steer_mux;

    localparam int NUM_IN  = 160;
    localparam int CHAN_W  = 8;
    localparam int ADDR_W  = 8;
    localparam int WORDS   = NUM_IN / 32;
    localparam int NUM_OUT = (NUM_IN + 63) / 64;

    logic               clk = 1'b0;
    logic               rst = 1'b1;
    logic [NUM_IN-1:0]  irq_in = '0;
    logic               bus_wr = 1'b0;
    logic               bus_rd = 1'b0;
    logic [ADDR_W-1:0]  bus_addr = '0;
    logic [31:0]        bus_wdata = '0;
    logic [31:0]        bus_rdata;
    logic [CHAN_W-1:0]  chan_sel;
    logic [NUM_OUT-1:0] irq_out;

    logic [NUM_IN-1:0]  m_mask = '0;
    logic [NUM_IN-1:0]  m_set  = '0;

    int checks = 0;
    int fails  = 0;

    always #2.5 clk = ~clk;

    irq_steer_mux #(.NUM_IN(NUM_IN), .CHAN_W(CHAN_W), .ADDR_W(ADDR_W)) i_irq_steer_mux (
        .clk(clk), .rst(rst), .irq_in(irq_in), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .chan_sel(chan_sel), .irq_out(irq_out)
    );

    function automatic logic [7:0] a_mask(input int w); return 8'(4 + 4*w); endfunction
    function automatic logic [7:0] a_set (input int w); return 8'(4*WORDS + 4 + 4*w); endfunction
    function automatic logic [7:0] a_stat(input int w); return 8'(8*WORDS + 4 + 4*w); endfunction

    function automatic logic [NUM_OUT-1:0] exp_out();
        logic [NUM_OUT-1:0] e = '0;
        for (int i = 0; i < NUM_IN; i++)
            if ((irq_in[i] | m_set[i]) & m_mask[i]) e[i/64] = 1'b1;
        return e;
    endfunction

    function automatic logic [31:0] exp_stat(input int w);
        int b = WORDS - 1 - w;
        return irq_in[b*32 +: 32] | m_set[b*32 +: 32];
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        int w;
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
        if (a >= 4 && a[1:0] == 0) begin
            w = int'(a) / 4 - 1;
            if (w < WORDS)
                m_mask[(WORDS-1-w)*32 +: 32] = d;
            else if (w < 2*WORDS)
                m_set[(WORDS-1-(w-WORDS))*32 +: 32] = m_set[(WORDS-1-(w-WORDS))*32 +: 32] | d;
            else if (w < 3*WORDS)
                m_set[(WORDS-1-(w-2*WORDS))*32 +: 32] = m_set[(WORDS-1-(w-2*WORDS))*32 +: 32] & ~d;
        end
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_rd = 1'b1; bus_addr = a;
        @(negedge clk);
        bus_rd = 1'b0;
        d = bus_rdata;
    endtask

    task automatic settle();
        @(negedge clk);
    endtask

    initial begin
        #(5.0 * 150000);
        fails++;
        checks++;
        $display("FAIL watchdog: actual hung expected done");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        logic [31:0] d;
        void'($urandom(32'd4242));
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1 reset state
        check("R1 out", 32'(irq_out), 32'd0);
        check("R1 chan", 32'(chan_sel), 32'd0);
        rd(a_mask(0), d); check("R1 mask", d, 32'd0);
        rd(a_set(WORDS-1), d); check("R1 set", d, 32'd0);

        // R2 mask readback and reversed mapping
        wr(a_mask(0), 32'hA5A5_0001);
        rd(a_mask(0), d); check("R2 readback", d, 32'hA5A5_0001);
        wr(a_mask(0), 32'h0);
        wr(a_mask(WORDS-1), 32'h1);
        irq_in[0] = 1'b1;
        settle();
        check("R6 in0 raises out0", 32'(irq_out), 32'(exp_out()));
        check("R6 out0 high", 32'(irq_out[0]), 32'd1);

        // R7 masked input ignored
        wr(a_mask(WORDS-1), 32'h0);
        settle();
        check("R7 masked in0", 32'(irq_out), 32'd0);
        wr(a_set(WORDS-1), 32'h2);
        settle();
        check("R7 masked set", 32'(irq_out), 32'd0);
        wr(a_stat(WORDS-1), 32'h2);

        // R3 status order
        irq_in = '0;
        irq_in[5] = 1'b1; irq_in[150] = 1'b1;
        rd(a_stat(WORDS-1), d); check("R3 status last word", d, 32'h20);
        rd(a_stat(0), d); check("R3 status word0", d, 32'h0040_0000);

        // R4 software set, R10 short last band
        irq_in = '0;
        wr(a_mask(0), 32'h0000_0020);
        wr(a_set(0), 32'h0000_0020);
        rd(a_set(0), d); check("R4 set readback", d, 32'h20);
        wr(a_set(0), 32'h0);
        rd(a_set(0), d); check("R4 zero write no effect", d, 32'h20);
        settle();
        check("R10 out2 only", 32'(irq_out), 32'b100);

        // R5 clear via status
        irq_in[133] = 1'b1;
        wr(a_stat(0), 32'h0);
        rd(a_set(0), d); check("R5 zero clear no effect", d, 32'h20);
        wr(a_stat(0), 32'h20);
        rd(a_set(0), d); check("R5 cleared", d, 32'h0);
        rd(a_stat(0), d); check("R5 raw still visible", d, 32'h20);
        irq_in[133] = 1'b0;
        settle();
        check("R6 falls", 32'(irq_out), 32'd0);

        // R8 channel select
        wr(8'h00, 32'h04); settle(); check("R8 onehot", 32'(chan_sel), 32'h04);
        wr(8'h00, 32'h06); settle(); check("R8 multi ignored", 32'(chan_sel), 32'h04);
        wr(8'h00, 32'h100); settle(); check("R8 wide ignored", 32'(chan_sel), 32'h04);
        rd(8'h00, d); check("R8 readback", d, 32'h04);
        wr(8'h00, 32'h0); settle(); check("R8 zero", 32'(chan_sel), 32'h0);

        // R9 read port
        wr(a_mask(1), 32'hDEAD_BEEF);
        rd(a_mask(1), d);
        @(negedge clk); @(negedge clk);
        check("R9 hold", bus_rdata, 32'hDEAD_BEEF);
        rd(8'h05, d); check("R9 unaligned", d, 32'h0);
        rd(8'(12*WORDS + 4), d); check("R9 unmapped", d, 32'h0);

        // R6 random patterns
        for (int it = 0; it < 400; it++) begin
            int kind = $urandom_range(0, 2);
            int w    = $urandom_range(0, WORDS - 1);
            logic [31:0] v = $urandom();
            for (int j = 0; j < NUM_IN / 32; j++) irq_in[j*32 +: 32] = $urandom() & $urandom();
            if (kind == 0) wr(a_mask(w), v);
            else if (kind == 1) wr(a_set(w), v & $urandom());
            else wr(a_stat(w), v);
            settle();
            check("R6 random out", 32'(irq_out), 32'(exp_out()));
            if (it % 8 == 0) begin
                rd(a_stat(w), d);
                check("R3 random status", d, exp_stat(w));
            end
        end

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule